// File: doc/BRIEF.md
# Feedback-Interlocked Half-Bridge Gate Controller

This block is the digital control core of a synchronous-buck half-bridge gate driver. It takes a PWM command and decides, on each clock, whether the high-side switch, the low-side switch or neither is commanded on. A switch may turn on only after the opposite switch is known to be off. The block does not use a fixed delay between complementary outputs. It waits for two sensed feedback levels: one says the low-side gate drive has fallen, and the other says the switch node has been released by the high-side switch. An optional minimum dead time, counted in clock cycles, is added after each feedback condition is met.

Three plain control inputs shape this behaviour. An enable input turns both drivers off when it is low. A rectifier-mode input turns synchronous rectification off, and then the low-side switch is never driven. An active-low clamp input forces the low-side switch on and the high-side switch off, ahead of every other input, to protect the output against a shorted high-side switch.

Every input passes through a two-flop synchronizer. The clamp and enable paths bypass the interlock state and act directly on the registered outputs. Each input therefore reaches the outputs three clocks after the edge that samples it. Feedback-gated turn-ons also pass through the interlock state, which adds one more clock. A build-time parameter selects whether the PWM command is read as active-high or active-low.

Top module: `halfbridge_gate_ctrl`

## Requirements
- R1: When `crowbar_n` is low, `lo_gate` is 1 and `hi_gate` is 0 from the third clock edge after the edge that samples it. This holds whatever the values of `drv_en`, `sync_rect_en`, `pwm_cmd` and the feedback inputs.
- R2: When `drv_en` is low and `crowbar_n` is high, both gate outputs are 0 from the third clock edge after the edge that samples them.
- R3: When `sync_rect_en` is low, and `crowbar_n` is high, `lo_gate` stays 0 with the same three-edge latency. `hi_gate` still follows the PWM command.
- R4: `hi_gate` rises only if `lo_gate_low` was 1 at the clock edge four edges before the edge on which `hi_gate` rises.
- R5: Apart from a clamp, `lo_gate` rises only if `sw_node_low` was 1 at the clock edge four edges before the edge on which `lo_gate` rises.
- R6: With `PWM_INVERT` = 0, a 1 on `pwm_cmd` requests the high side and a 0 requests the low side. With `PWM_INVERT` = 1 the two levels swap roles.
- R7: `hi_gate` and `lo_gate` are never 1 in the same cycle.
- R8: After a side has been waiting for longer than the blanking time of three clocks, a turn-on follows exactly 4 + `min_dead` clock edges after the feedback input changes to 1. With `min_dead` = 0 the turn-on is gated by feedback alone.
- R9: If the PWM command reverses while a turn-on is pending, that turn-on is cancelled without any output pulse. The block then waits for the opposite side's feedback condition.
- R10: During reset both outputs are 0. The first turn-on after reset still waits for its feedback condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_cmd | input | 1 | PWM command; its polarity is set by `PWM_INVERT` |
| drv_en | input | 1 | 1 enables the drivers; 0 turns both outputs off |
| sync_rect_en | input | 1 | 1 selects synchronous rectification; 0 keeps the low side off |
| crowbar_n | input | 1 | Active-low clamp request: low side on, high side off |
| lo_gate_low | input | 1 | Sense input: 1 means the low-side gate drive is low |
| sw_node_low | input | 1 | Sense input: 1 means the switch node is low |
| min_dead | input | DT_W | Extra dead time in clocks, added after feedback is met |
| hi_gate | output | 1 | Registered high-side gate command |
| lo_gate | output | 1 | Registered low-side gate command |

## Verification
The bench drives the controller through a plant that feeds each gate output back after a delay. It also has forcing switches that can hold either feedback input in its "not yet off" state. Holding the low-side feedback at busy after reset, and holding the switch-node feedback at busy after a high-side period, show that each turn-on waits for its own sense input and not for the other one. Reversing the PWM command while feedback is still held busy separates a cancelled turn-on from a glitch pulse. Runs with `min_dead` at 0 and at 5 separate the pure feedback gate from the added count. Random PWM edges and dead-time values, applied with the clamp, enable and rectifier-mode inputs at various settings, are compared on every clock against a behavioural model.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
  // Interlock leg states
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM_HI,
    ST_HI,
    ST_ARM_LO,
    ST_LO
  } leg_state_e;

  // Bit positions inside the synchronized input vector
  localparam int unsigned N_IN    = 6;
  localparam int unsigned IX_PWM  = 0;
  localparam int unsigned IX_EN   = 1;
  localparam int unsigned IX_SYNC = 2;
  localparam int unsigned IX_CRWN = 3;
  localparam int unsigned IX_LSFB = 4;
  localparam int unsigned IX_SWFB = 5;

  // Safe values while in reset: clamp released, all else inactive
  localparam logic [N_IN-1:0] IN_RST_VAL = 6'b001000;
endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
  parameter int unsigned WIDTH = 6,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hbg_interlock.sv
module hbg_interlock
  import hbg_pkg::*;
#(
  parameter int unsigned DT_W = 8,
  parameter int unsigned BLANK = 3,
  parameter bit PWM_INVERT = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwm_s,
  input  logic            en_s,
  input  logic            sync_s,
  input  logic            clamp_s,
  input  logic            ls_low_s,
  input  logic            sw_low_s,
  input  logic [DT_W-1:0] dead,
  output logic            want_hi,
  output logic            want_lo
);
  localparam int unsigned CNT_W = $clog2((1 << DT_W) + BLANK + 1);

  leg_state_e st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] blank_c, target_c;
  logic cmd_hi;

  assign cmd_hi   = pwm_s ^ PWM_INVERT;
  assign blank_c  = CNT_W'(BLANK);
  assign target_c = blank_c + CNT_W'(dead);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (clamp_s || !en_s) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (cmd_hi) st_d = ST_ARM_HI;
          else if (sync_s) st_d = ST_ARM_LO;
        end
        ST_ARM_HI: begin
          if (!cmd_hi) st_d = sync_s ? ST_ARM_LO : ST_IDLE;
          else if (cnt_q < blank_c) cnt_d = cnt_q + 1'b1;
          else if (ls_low_s) begin
            if (cnt_q == target_c) st_d = ST_HI;
            else cnt_d = cnt_q + 1'b1;
          end else cnt_d = blank_c;
        end
        ST_HI: begin
          if (!cmd_hi) st_d = sync_s ? ST_ARM_LO : ST_IDLE;
        end
        ST_ARM_LO: begin
          if (cmd_hi) st_d = ST_ARM_HI;
          else if (!sync_s) st_d = ST_IDLE;
          else if (cnt_q < blank_c) cnt_d = cnt_q + 1'b1;
          else if (sw_low_s) begin
            if (cnt_q == target_c) st_d = ST_LO;
            else cnt_d = cnt_q + 1'b1;
          end else cnt_d = blank_c;
        end
        ST_LO: begin
          if (cmd_hi) st_d = ST_ARM_HI;
          else if (!sync_s) st_d = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
    if (st_d != st_q) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign want_hi = (st_q == ST_HI);
  assign want_lo = (st_q == ST_LO);
endmodule

// File: rtl/hbg_drive.sv
module hbg_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic clamp_s,
  input  logic en_s,
  input  logic sync_s,
  input  logic want_hi,
  input  logic want_lo,
  output logic hi_q,
  output logic lo_q
);
  // Clamp, enable and mode act here directly, one register from the pins' sync
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      hi_q <= !clamp_s && en_s && want_hi;
      lo_q <= clamp_s || (en_s && sync_s && want_lo);
    end
  end
endmodule

// File: rtl/halfbridge_gate_ctrl.sv
module halfbridge_gate_ctrl
  import hbg_pkg::*;
#(
  parameter int unsigned DT_W = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit PWM_INVERT = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwm_cmd,
  input  logic            drv_en,
  input  logic            sync_rect_en,
  input  logic            crowbar_n,
  input  logic            lo_gate_low,
  input  logic            sw_node_low,
  input  logic [DT_W-1:0] min_dead,
  output logic            hi_gate,
  output logic            lo_gate
);
  // Feedback older than the sync path plus output register is trusted
  localparam int unsigned BLANK = SYNC_STAGES + 1;

  logic [N_IN-1:0] raw_v, syn_v;
  logic want_hi, want_lo, clamp_s;

  assign raw_v[IX_PWM]  = pwm_cmd;
  assign raw_v[IX_EN]   = drv_en;
  assign raw_v[IX_SYNC] = sync_rect_en;
  assign raw_v[IX_CRWN] = crowbar_n;
  assign raw_v[IX_LSFB] = lo_gate_low;
  assign raw_v[IX_SWFB] = sw_node_low;

  hbg_sync #(
    .WIDTH(N_IN), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST_VAL)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_v), .q(syn_v)
  );

  assign clamp_s = !syn_v[IX_CRWN];

  hbg_interlock #(
    .DT_W(DT_W), .BLANK(BLANK), .PWM_INVERT(PWM_INVERT)
  ) u_lock (
    .clk(clk), .rst_n(rst_n),
    .pwm_s(syn_v[IX_PWM]), .en_s(syn_v[IX_EN]), .sync_s(syn_v[IX_SYNC]),
    .clamp_s(clamp_s), .ls_low_s(syn_v[IX_LSFB]), .sw_low_s(syn_v[IX_SWFB]),
    .dead(min_dead), .want_hi(want_hi), .want_lo(want_lo)
  );

  hbg_drive u_drv (
    .clk(clk), .rst_n(rst_n), .clamp_s(clamp_s),
    .en_s(syn_v[IX_EN]), .sync_s(syn_v[IX_SYNC]),
    .want_hi(want_hi), .want_lo(want_lo),
    .hi_q(hi_gate), .lo_q(lo_gate)
  );
endmodule

// File: rtl/halfbridge_gate_ctrl_chk.sv
module halfbridge_gate_ctrl_chk #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic drv_en,
  input logic sync_rect_en,
  input logic crowbar_n,
  input logic lo_gate_low,
  input logic sw_node_low,
  input logic hi_gate,
  input logic lo_gate
);
  localparam int unsigned LAT = SYNC_STAGES + 1;
  localparam int unsigned FBL = SYNC_STAGES + 2;

  logic [3:0] cyc;
  logic hist_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= '0;
    else if (cyc != 4'hF) cyc <= cyc + 1'b1;
  end
  assign hist_ok = (cyc > 4'(FBL));

  // R7
  never_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_gate && lo_gate));

  // R1
  clamp_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && !$past(crowbar_n, LAT)) |-> (lo_gate && !hi_gate));

  // R2
  disable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && $past(crowbar_n, LAT) && !$past(drv_en, LAT)) |-> (!hi_gate && !lo_gate));

  // R3
  nonsync_lo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && $past(crowbar_n, LAT) && !$past(sync_rect_en, LAT)) |-> !lo_gate);

  // R4
  hi_wait_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && $rose(hi_gate)) |-> $past(lo_gate_low, FBL));

  // R5
  lo_wait_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && $rose(lo_gate) && $past(crowbar_n, LAT)) |-> $past(sw_node_low, FBL));
endmodule

bind halfbridge_gate_ctrl halfbridge_gate_ctrl_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .drv_en(drv_en), .sync_rect_en(sync_rect_en),
  .crowbar_n(crowbar_n), .lo_gate_low(lo_gate_low), .sw_node_low(sw_node_low),
  .hi_gate(hi_gate), .lo_gate(lo_gate)
);

// File: tb/halfbridge_gate_ctrl_bench.sv
`timescale 1ns/1ps
module halfbridge_gate_ctrl_bench;
  localparam int DT_W = 8;
  localparam int PD = 3;          // plant feedback delay in clocks
  localparam int BLANK_M = 3;     // blanking time from the requirements

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm = 1'b0, en = 1'b0, syn = 1'b1, crw_n = 1'b1;
  logic [DT_W-1:0] dead = '0;
  logic force_ls_busy = 1'b0, force_sw_high = 1'b0;
  logic hi, lo;
  logic [PD-1:0] ls_line = '1, hs_line = '1;
  logic ls_fb, sw_fb;
  logic pwm_i = 1'b1;
  logic hi_i, lo_i;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R10";
  int hi_rises = 0, lo_rises = 0;
  logic hi_prev = 1'b0, lo_prev = 1'b0;

  always #10 clk = ~clk;

  assign ls_fb = force_ls_busy ? 1'b0 : ls_line[PD-1];
  assign sw_fb = force_sw_high ? 1'b0 : hs_line[PD-1];

  halfbridge_gate_ctrl #(.DT_W(DT_W)) u_halfbridge_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .pwm_cmd(pwm), .drv_en(en), .sync_rect_en(syn),
    .crowbar_n(crw_n), .lo_gate_low(ls_fb), .sw_node_low(sw_fb),
    .min_dead(dead), .hi_gate(hi), .lo_gate(lo)
  );

  halfbridge_gate_ctrl #(.DT_W(DT_W), .PWM_INVERT(1'b1)) u_inv (
    .clk(clk), .rst_n(rst_n), .pwm_cmd(pwm_i), .drv_en(1'b1), .sync_rect_en(1'b1),
    .crowbar_n(1'b1), .lo_gate_low(!lo_i), .sw_node_low(!hi_i),
    .min_dead(8'd0), .hi_gate(hi_i), .lo_gate(lo_i)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Behavioural reference: two-sample input delay, mode 0 idle,1 arm-hi,2 hi,3 arm-lo,4 lo
  logic [5:0] m1 = 6'b001000, m2 = 6'b001000;
  int mode = 0, wcnt = 0;
  logic exp_hi = 1'b0, exp_lo = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m1 = 6'b001000; m2 = 6'b001000; mode = 0; wcnt = 0;
      exp_hi = 1'b0; exp_lo = 1'b0;
    end else begin
      automatic logic s_pwm = m2[0], s_en = m2[1], s_syn = m2[2];
      automatic logic s_clamp = !m2[3], s_ls = m2[4], s_sw = m2[5];
      automatic int nm = mode;
      exp_hi = !s_clamp && s_en && (mode == 2);
      exp_lo = s_clamp || (s_en && s_syn && (mode == 4));
      if (s_clamp || !s_en) nm = 0;
      else if (mode == 0) nm = s_pwm ? 1 : (s_syn ? 3 : 0);
      else if (mode == 2) begin if (!s_pwm) nm = s_syn ? 3 : 0; end
      else if (mode == 4) begin
        if (s_pwm) nm = 1; else if (!s_syn) nm = 0;
      end else begin
        automatic logic want = (mode == 1) ? s_pwm : !s_pwm;
        automatic logic fb = (mode == 1) ? s_ls : s_sw;
        if (!want) nm = (mode == 3) ? 1 : (s_syn ? 3 : 0);
        else if (mode == 3 && !s_syn) nm = 0;
        else if (wcnt < BLANK_M) wcnt++;
        else if (fb) begin
          if (wcnt == BLANK_M + int'(dead)) nm = mode + 1; else wcnt++;
        end else wcnt = BLANK_M;
      end
      if (nm != mode) wcnt = 0;
      mode = nm;
      m2 = m1;
      m1 = {sw_fb, ls_fb, crw_n, syn, en, pwm};
    end
  end

  // Per-cycle comparison, edge monitors and plant feedback lines
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(hi === exp_hi, {cur_req, " model hi"}, int'(hi), int'(exp_hi));
      chk(lo === exp_lo, {cur_req, " model lo"}, int'(lo), int'(exp_lo));
      chk(!(hi && lo), "R7 both on", int'(hi && lo), 0);
    end
    if (hi && !hi_prev) hi_rises++;
    if (lo && !lo_prev) lo_rises++;
    hi_prev = hi; lo_prev = lo;
    ls_line = {ls_line[PD-2:0], !lo};
    hs_line = {hs_line[PD-2:0], !hi};
  end

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int k;
    wait_n(4);
    // R10 reset state
    chk(hi == 0 && lo == 0, "R10 reset outputs", int'({hi, lo}), 0);
    rst_n = 1'b1;

    // R10/R4: first turn-on held off while low-side feedback reads busy
    force_ls_busy = 1'b1; en = 1'b1; pwm = 1'b1;
    wait_n(20);
    chk(hi == 0, "R10 first turn-on waits", int'(hi), 0);
    cur_req = "R4";
    force_ls_busy = 1'b0;
    wait_n(15);
    chk(hi == 1, "R4 hi after feedback", int'(hi), 1);

    // R5: low side waits on switch node
    cur_req = "R5";
    force_sw_high = 1'b1; pwm = 1'b0;
    wait_n(20);
    chk(lo == 0 && hi == 0, "R5 lo held off", int'({hi, lo}), 0);
    cur_req = "R8";
    force_sw_high = 1'b0; k = 0;
    do begin @(negedge clk); k++; end while (!lo && k < 50);
    chk(k == 4, "R8 zero dead-time latency", k, 4);

    // R8: programmed dead time adds cycles
    dead = 8'd5; pwm = 1'b1;
    wait_n(20);
    force_sw_high = 1'b1; pwm = 1'b0;
    wait_n(20);
    force_sw_high = 1'b0; k = 0;
    do begin @(negedge clk); k++; end while (!lo && k < 50);
    chk(k == 9, "R8 dead-time 5 latency", k, 9);
    dead = 8'd0;

    // R9: reversal while high side pending
    cur_req = "R9";
    wait_n(5);
    hi_rises = 0;
    force_ls_busy = 1'b1; pwm = 1'b1;
    wait_n(10);
    pwm = 1'b0;
    wait_n(15);
    chk(hi_rises == 0, "R9 no hi pulse", hi_rises, 0);
    chk(lo == 1, "R9 back to lo", int'(lo), 1);
    force_ls_busy = 1'b0;
    // R9: reversal while low side pending
    pwm = 1'b1;
    wait_n(15);
    lo_rises = 0;
    force_sw_high = 1'b1; pwm = 1'b0;
    wait_n(8);
    pwm = 1'b1;
    wait_n(15);
    chk(lo_rises == 0, "R9 no lo pulse", lo_rises, 0);
    chk(hi == 1, "R9 hi resumes", int'(hi), 1);
    force_sw_high = 1'b0;

    // R3: nonsynchronous mode
    cur_req = "R3";
    syn = 1'b0; lo_rises = 0;
    for (int i = 0; i < 6; i++) begin
      pwm = ~pwm;
      wait_n(14);
      chk(hi == pwm, "R3 hi follows pwm", int'(hi), int'(pwm));
    end
    chk(lo_rises == 0, "R3 lo stays off", lo_rises, 0);
    syn = 1'b1;
    wait_n(10);

    // R2: disabled
    cur_req = "R2";
    pwm = 1'b1; en = 1'b0;
    wait_n(6);
    chk(hi == 0 && lo == 0, "R2 off with pwm hi", int'({hi, lo}), 0);
    pwm = 1'b0;
    wait_n(10);
    chk(hi == 0 && lo == 0, "R2 off with pwm lo", int'({hi, lo}), 0);

    // R1: clamp overrides enable and pwm
    cur_req = "R1";
    crw_n = 1'b0;
    wait_n(3);
    chk(lo == 1 && hi == 0, "R1 clamp while disabled", int'({hi, lo}), 1);
    en = 1'b1; pwm = 1'b1;
    wait_n(10);
    chk(lo == 1 && hi == 0, "R1 clamp over pwm", int'({hi, lo}), 1);
    crw_n = 1'b1;
    wait_n(20);
    chk(hi == 1 && lo == 0, "R1 recovery", int'({hi, lo}), 2);

    // R6: inverting polarity instance
    pwm_i = 1'b0;
    wait_n(12);
    chk(hi_i == 1 && lo_i == 0, "R6 inverted low->hi", int'({hi_i, lo_i}), 2);
    pwm_i = 1'b1;
    wait_n(12);
    chk(lo_i == 1 && hi_i == 0, "R6 inverted high->lo", int'({hi_i, lo_i}), 1);

    // Random PWM edges and dead times against the model
    cur_req = "R8";
    for (int i = 0; i < 120; i++) begin
      pwm = $urandom_range(0, 1);
      dead = 8'($urandom_range(0, 3));
      if ((i % 17) == 5) syn = ~syn;
      if ((i % 29) == 11) crw_n = 1'b0;
      if ((i % 29) == 14) crw_n = 1'b1;
      wait_n($urandom_range(1, 9));
    end
    crw_n = 1'b1;
    wait_n(10);
    finish_run();
  end
endmodule